// File: doc/BRIEF.md
# Integer Three-Way Compare and Conditional Branch Unit

This unit evaluates the integer ordering and conditional-branch operations of a 64-bit register machine. In compare mode it orders a register operand against either a second register operand or a 64-bit immediate. It reads both as unsigned or both as signed, as selected. It returns the ordering as a full-width two's-complement value: minus one, zero or plus one.

In branch mode it tests two register operands against a 3-bit condition code. It reports whether the branch is taken and gives the address of the next instruction.

Each branch instruction is five bytes long: one opcode byte, two register bytes and a 16-bit signed offset. The offset is measured from the address of its own first byte, which lies three bytes past the opcode. A taken branch therefore lands at the instruction address plus three plus the sign-extended offset. A branch that is not taken continues at the instruction address plus five.

All results are registered. They appear one clock after a valid request, together with a one-cycle valid strobe.

Top module: `cmp_branch_unit`

## Requirements
- R1: A compare returns the 64-bit value 0xFFFF_FFFF_FFFF_FFFF (-1) when the first operand is below the second, 0 when the two are equal, and 1 when the first is above.
- R2: With `signedCmp` = 0, a compare orders the operands as unsigned 64-bit integers. For example, 0xFFFF_FFFF_FFFF_FFFF against 1 gives +1.
- R3: With `signedCmp` = 1, a compare orders the operands as signed 64-bit integers. For example, 0xFFFF_FFFF_FFFF_FFFF against 1 gives -1.
- R4: With `useImm` = 1, a compare uses `immVal` as the second operand, and `opB` has no effect on the result. The signed flavour reads the immediate as signed.
- R5: Condition codes EQ (3'd0) and NE (3'd1) test all 64 bits for equality, with no sign interpretation.
- R6: Condition codes LTU (3'd2) and GTU (3'd3) take the branch when `opA` is below or above `opB` as unsigned values. The `signedCmp` input has no effect on branches.
- R7: Condition codes LTS (3'd4) and GTS (3'd5) take the branch when `opA` is below or above `opB` as signed values.
- R8: A taken branch sets `nextAddr` to `instAddr` + 3 + the sign-extended `brOffset`, computed modulo 2^64.
- R9: A branch that is not taken sets `taken` = 0 and `nextAddr` = `instAddr` + 5.
- R10: Condition codes 3'd6 and 3'd7 raise `illegalCond`. They never take the branch, and `nextAddr` is the sequential address `instAddr` + 5.
- R11: After reset, `outValid` and all result outputs are zero. `outValid` is high exactly in the cycle after an accepted request (`inValid` = 1). Results hold their values while no request arrives.
- R12: A compare result has `taken` = 0, `illegalCond` = 0 and `nextAddr` = 0. A branch result has `cmpResult` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| isBranch | input | 1 | 1: branch request, 0: compare request |
| useImm | input | 1 | Compare against `immVal` instead of `opB` |
| signedCmp | input | 1 | Compare flavour: 1 signed, 0 unsigned |
| condCode | input | 3 | Branch condition (EQ=0, NE=1, LTU=2, GTU=3, LTS=4, GTS=5) |
| opA | input | 64 | First register operand |
| opB | input | 64 | Second register operand |
| immVal | input | 64 | Immediate second operand for compares |
| instAddr | input | 64 | Address of the branch opcode byte |
| brOffset | input | 16 | Signed branch offset |
| outValid | output | 1 | Result strobe, one cycle after a request |
| cmpResult | output | 64 | Three-way ordering result |
| taken | output | 1 | Branch taken |
| nextAddr | output | 64 | Next instruction address for branches |
| illegalCond | output | 1 | Unsupported condition code seen |

## Verification
Several properties are checked on every result cycle:
- the valid strobe follows each accepted request by exactly one cycle;
- a compare result is always one of the three legal encodings;
- compares never raise `taken` or `illegalCond`;
- an illegal condition never takes the branch;
- every untaken branch points at the sequential address.

Other behaviour depends on the operand values and only the scenarios can show it. This covers the choice between signed and unsigned ordering, whether the immediate or `opB` is used, and the exact taken target. The scenarios include negative offsets and addresses that wrap past 2^64.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

  // Branch condition codes as seen on the condCode input
  localparam logic [2:0] CC_EQ  = 3'd0;
  localparam logic [2:0] CC_NE  = 3'd1;
  localparam logic [2:0] CC_LTU = 3'd2;
  localparam logic [2:0] CC_GTU = 3'd3;
  localparam logic [2:0] CC_LTS = 3'd4;
  localparam logic [2:0] CC_GTS = 3'd5;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // capture a new result this edge
    logic branch;     // request is a branch
    logic selImm;     // second operand comes from the immediate
    logic signedOrd;  // order operands as signed values
    logic wantEq;
    logic wantNe;
    logic wantLt;
    logic wantGt;
    logic badCond;    // condition code outside the legal set
  } cbu_ctrl_s;

endpackage

// File: rtl/cbu_ctrl.sv
module cbu_ctrl
  import cbu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       isBranch,
  input  logic       useImm,
  input  logic       signedCmp,
  input  logic [2:0] condCode,
  output cbu_ctrl_s  strobes,
  output logic       outValid
);

  always_comb begin
    strobes           = '0;
    strobes.load      = inValid;
    strobes.branch    = isBranch;
    strobes.selImm    = useImm & ~isBranch;
    strobes.signedOrd = signedCmp;
    if (isBranch) begin
      strobes.signedOrd = 1'b0;
      unique case (condCode)
        CC_EQ:  strobes.wantEq = 1'b1;
        CC_NE:  strobes.wantNe = 1'b1;
        CC_LTU: strobes.wantLt = 1'b1;
        CC_GTU: strobes.wantGt = 1'b1;
        CC_LTS: begin
          strobes.wantLt    = 1'b1;
          strobes.signedOrd = 1'b1;
        end
        CC_GTS: begin
          strobes.wantGt    = 1'b1;
          strobes.signedOrd = 1'b1;
        end
        default: strobes.badCond = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);  // R11
  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);  // R11

endmodule

// File: rtl/cbu_datapath.sv
module cbu_datapath
  import cbu_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int OFF_W    = 16,
  parameter int OFF_POS  = 3,
  parameter int INSN_LEN = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  cbu_ctrl_s         strobes,
  input  logic              outValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] immVal,
  input  logic [DATA_W-1:0] instAddr,
  input  logic [OFF_W-1:0]  brOffset,
  output logic [DATA_W-1:0] cmpResult,
  output logic              taken,
  output logic [DATA_W-1:0] nextAddr,
  output logic              illegalCond
);

  localparam int EXT_W = DATA_W - OFF_W;
  localparam logic [DATA_W-1:0] MINUS_ONE = '1;
  localparam logic [DATA_W-1:0] PLUS_ONE  = DATA_W'(1);
  localparam logic [DATA_W-1:0] POS_STEP  = DATA_W'(OFF_POS);
  localparam logic [DATA_W-1:0] LEN_STEP  = DATA_W'(INSN_LEN);

  logic [DATA_W-1:0] rhs;
  logic              isEq, isLt, isGt, ltUns, ltSgn, condHit, takeNow;
  logic [DATA_W-1:0] ordVal, offExt, jumpAddr, seqAddr;
  logic              branchQ;

  // Operand ordering
  always_comb begin
    rhs   = strobes.selImm ? immVal : opB;
    isEq  = (opA == rhs);
    ltUns = (opA < rhs);
    ltSgn = ($signed(opA) < $signed(rhs));
    isLt  = strobes.signedOrd ? ltSgn : ltUns;
    isGt  = ~isLt & ~isEq;
    if (isLt)      ordVal = MINUS_ONE;
    else if (isEq) ordVal = '0;
    else           ordVal = PLUS_ONE;
  end

  // Condition and address arithmetic
  always_comb begin
    condHit = (strobes.wantEq & isEq) | (strobes.wantNe & ~isEq) |
              (strobes.wantLt & isLt) | (strobes.wantGt & isGt);
    takeNow  = strobes.branch & condHit & ~strobes.badCond;
    offExt   = {{EXT_W{brOffset[OFF_W-1]}}, brOffset};
    jumpAddr = instAddr + POS_STEP + offExt;
    seqAddr  = instAddr + LEN_STEP;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpResult   <= '0;
      taken       <= 1'b0;
      nextAddr    <= '0;
      illegalCond <= 1'b0;
      branchQ     <= 1'b0;
    end else if (strobes.load) begin
      branchQ     <= strobes.branch;
      cmpResult   <= strobes.branch ? '0 : ordVal;
      taken       <= takeNow;
      illegalCond <= strobes.branch & strobes.badCond;
      if (!strobes.branch) nextAddr <= '0;
      else if (takeNow)    nextAddr <= jumpAddr;
      else                 nextAddr <= seqAddr;
    end
  end

  AST_ORDER_TRIO: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !branchQ) |->
      (cmpResult == MINUS_ONE || cmpResult == '0 || cmpResult == PLUS_ONE));  // R1
  AST_CMP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !branchQ) |-> (!taken && !illegalCond && nextAddr == '0));  // R12
  AST_SEQ_WHEN_UNTAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && branchQ && !taken) |-> (nextAddr == $past(instAddr) + LEN_STEP));  // R9
  AST_ILLEGAL_NEVER_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    illegalCond |-> !taken);  // R10

endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
  import cbu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        isBranch,
  input  logic        useImm,
  input  logic        signedCmp,
  input  logic [2:0]  condCode,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  input  logic [63:0] immVal,
  input  logic [63:0] instAddr,
  input  logic [15:0] brOffset,
  output logic        outValid,
  output logic [63:0] cmpResult,
  output logic        taken,
  output logic [63:0] nextAddr,
  output logic        illegalCond
);

  cbu_ctrl_s strobes;

  cbu_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .isBranch  (isBranch),
    .useImm    (useImm),
    .signedCmp (signedCmp),
    .condCode  (condCode),
    .strobes   (strobes),
    .outValid  (outValid)
  );

  cbu_datapath #(
    .DATA_W   (64),
    .OFF_W    (16),
    .OFF_POS  (3),
    .INSN_LEN (5)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .outValid    (outValid),
    .opA         (opA),
    .opB         (opB),
    .immVal      (immVal),
    .instAddr    (instAddr),
    .brOffset    (brOffset),
    .cmpResult   (cmpResult),
    .taken       (taken),
    .nextAddr    (nextAddr),
    .illegalCond (illegalCond)
  );

endmodule

// File: tb/sim_cmp_branch_unit.sv
`timescale 1ns/1ps
module sim_cmp_branch_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, isBranch = 1'b0, useImm = 1'b0, signedCmp = 1'b0;
  logic [2:0]  condCode = 3'd0;
  logic [63:0] opA = '0, opB = '0, immVal = '0, instAddr = '0;
  logic [15:0] brOffset = '0;
  logic        outValid, taken, illegalCond;
  logic [63:0] cmpResult, nextAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [63:0] res;
    logic        tk;
    logic [63:0] nxt;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t sb[$];
  logic [63:0] lastRes = '0;

  always #10 clk = ~clk;  // 50 MHz

  cmp_branch_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .isBranch(isBranch),
    .useImm(useImm), .signedCmp(signedCmp), .condCode(condCode),
    .opA(opA), .opB(opB), .immVal(immVal), .instAddr(instAddr),
    .brOffset(brOffset), .outValid(outValid), .cmpResult(cmpResult),
    .taken(taken), .nextAddr(nextAddr), .illegalCond(illegalCond)
  );

  // Expected values derived from the requirement text
  function automatic exp_t predict(input logic br, input logic imm, input logic sgn,
                                   input logic [2:0] cc, input logic [63:0] a,
                                   input logic [63:0] b, input logic [63:0] i,
                                   input logic [63:0] pc, input logic [15:0] off,
                                   input string tag);
    exp_t e;
    logic [63:0] r;
    logic below, above, same;
    e.tag = tag; e.res = '0; e.tk = 1'b0; e.nxt = '0; e.ill = 1'b0;
    if (!br) begin
      r = imm ? i : b;
      same  = (a == r);
      below = sgn ? ($signed(a) < $signed(r)) : (a < r);
      e.res = below ? 64'hFFFF_FFFF_FFFF_FFFF : (same ? 64'd0 : 64'd1);
    end else begin
      same = (a == b);
      case (cc)
        3'd0: e.tk = same;
        3'd1: e.tk = !same;
        3'd2: e.tk = a < b;
        3'd3: e.tk = a > b;
        3'd4: e.tk = $signed(a) < $signed(b);
        3'd5: e.tk = $signed(a) > $signed(b);
        default: e.ill = 1'b1;
      endcase
      above = e.tk;
      e.nxt = above ? pc + 64'd3 + {{48{off[15]}}, off} : pc + 64'd5;
    end
    return e;
  endfunction

  task automatic send(input logic br, input logic imm, input logic sgn,
                      input logic [2:0] cc, input logic [63:0] a, input logic [63:0] b,
                      input logic [63:0] i, input logic [63:0] pc,
                      input logic [15:0] off, input string tag);
    @(negedge clk);
    inValid = 1'b1; isBranch = br; useImm = imm; signedCmp = sgn; condCode = cc;
    opA = a; opB = b; immVal = i; instAddr = pc; brOffset = off;
    sb.push_back(predict(br, imm, sgn, cc, a, b, i, pc, off, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Monitor: pop and compare whenever a result strobe is seen
  always @(negedge clk) begin
    if (rstN && outValid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R11: unexpected outValid, expected none");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (cmpResult !== e.res || taken !== e.tk || nextAddr !== e.nxt ||
            illegalCond !== e.ill) begin
          errors++;
          $display("FAIL %s: got res=%h tk=%b nxt=%h ill=%b, expected res=%h tk=%b nxt=%h ill=%b",
                   e.tag, cmpResult, taken, nextAddr, illegalCond,
                   e.res, e.tk, e.nxt, e.ill);
        end
        lastRes = cmpResult;
      end
    end
  end

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    checks++;
    if (outValid !== 1'b0 || cmpResult !== '0 || taken !== 1'b0 ||
        nextAddr !== '0 || illegalCond !== 1'b0) begin
      errors++;
      $display("FAIL R11: reset outputs v=%b r=%h t=%b n=%h i=%b, expected all zero",
               outValid, cmpResult, taken, nextAddr, illegalCond);
    end

    // R1 / R2 unsigned compares
    send(0, 0, 0, 0, 64'd3, 64'd7, 0, 0, 0, "R1 less");
    send(0, 0, 0, 0, 64'd7, 64'd7, 0, 0, 0, "R1 equal");
    send(0, 0, 0, 0, 64'd9, 64'd7, 0, 0, 0, "R1 greater");
    send(0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0, "R2 unsigned big");
    // R3 signed compares
    send(0, 0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0, "R3 signed neg");
    send(0, 0, 1, 0, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0, 0, "R3 extremes");
    // R4 immediate compares, opB set to mislead
    send(0, 1, 0, 0, 64'd5, 64'd9, 64'd5, 0, 0, "R4 imm equal");
    send(0, 1, 1, 0, 64'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R4 imm signed");
    send(0, 1, 0, 0, 64'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R4 imm unsigned");
    // R5 equality branches
    send(1, 0, 0, 3'd0, 64'hA5A5, 64'hA5A5, 0, 64'h1000, 16'h0040, "R5 eq taken");
    send(1, 0, 0, 3'd0, 64'h1_0000_A5A5, 64'hA5A5, 0, 64'h1000, 16'h0040, "R5 eq high bits");
    send(1, 0, 0, 3'd1, 64'h1_0000_A5A5, 64'hA5A5, 0, 64'h2000, 16'h0010, "R5 ne taken");
    // R6 unsigned relations, signedCmp set to show it has no effect
    send(1, 0, 1, 3'd2, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 64'h3000, 16'h0020, "R6 ltu taken");
    send(1, 0, 1, 3'd3, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 64'h3000, 16'h0020, "R6 gtu untaken");
    // R7 signed relations
    send(1, 0, 0, 3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 64'h4000, 16'h0008, "R7 lts taken");
    send(1, 0, 0, 3'd5, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 64'h4000, 16'h0008, "R7 gts taken");
    send(1, 0, 0, 3'd5, 64'd1, 64'd1, 0, 64'h4000, 16'h0008, "R7 gts equal untaken");
    // R8 target arithmetic: negative offset and wrap
    send(1, 0, 0, 3'd0, 0, 0, 0, 64'h1000, 16'hFFF0, "R8 negative offset");
    send(1, 0, 0, 3'd0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFE, 16'h0010, "R8 wrap");
    send(1, 0, 0, 3'd0, 0, 0, 0, 64'h10, 16'h8000, "R8 min offset wrap");
    // R9 untaken sequential
    send(1, 0, 0, 3'd1, 64'd4, 64'd4, 0, 64'h5000, 16'h0100, "R9 untaken");
    // R10 illegal codes
    send(1, 0, 0, 3'd6, 64'd1, 64'd2, 0, 64'h6000, 16'h0004, "R10 code6");
    send(1, 0, 0, 3'd7, 64'd2, 64'd2, 0, 64'h6000, 16'h0004, "R10 code7");
    // R12 branch clears compare result, compare after branch clears branch fields
    send(1, 0, 0, 3'd2, 64'd9, 64'd1, 0, 64'h7000, 16'h0002, "R12 branch res zero");
    send(0, 0, 0, 3'd0, 64'd1, 64'd9, 0, 64'h7000, 16'h0002, "R12 compare quiet");

    // R11 hold: no request for two cycles
    idle();
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || cmpResult !== 64'hFFFF_FFFF_FFFF_FFFF) begin
      errors++;
      $display("FAIL R11: idle v=%b r=%h, expected v=0 r=%h",
               outValid, cmpResult, 64'hFFFF_FFFF_FFFF_FFFF);
    end
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R11: %0d results missing, expected 0", sb.size());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule